// File: doc/BRIEF.md
# Element-Indexed DMA Address Generator

This block is the address engine of one DMA channel. It moves elements of one, two or four bytes from a 64-bit peripheral port to a 32-bit memory port. It does not carry data. For each element it issues a read request on the peripheral side, then a write request on the memory side. Each request comes with its byte-lane strobes and a flag that says whether the beat continues the previous address of the same direction. Requests leave one per cycle on a valid/ready handshake.

A transfer is set up by the options (element size, source update mode, destination update mode), the two start addresses, an element count and a signed element index, all sampled on a start pulse. Each side either holds its address or moves it by the index after every element. The index is never applied inside an element.

One case is handled differently. With word elements, at least one side held fixed and a count above one, each 64-bit read is followed by two 32-bit writes at adjacent addresses. This mode has its own preconditions. Illegal setups raise an error flag and start nothing.

Top module: `dma_addr_gen`

## Requirements
- R1: On a start, the error flag is set and no request or done follows in any of these cases: size code 11b; an update mode of 01b or 10b; a source address, destination address or index that is not a multiple of the element size in bytes. Size codes are 00b word (4 bytes), 01b half-word (2 bytes) and 10b byte. The error flag stays set until the next start, which reloads it.
- R2: For each element the block issues a read (req_write=0) at the source address, then a write (req_write=1) at the destination address. While req_valid is high and req_ready is low, the request (kind, address, strobes) holds unchanged.
- R3: Mode 00b keeps an address fixed. Mode 11b adds the sign-extended 16-bit index to the address after each element (after each pair in the mode of R4).
- R4: Paired mode is used when the size is word, at least one mode is 00b and the count is above 1. In this mode each read has strobe 0xFF and is followed by writes at the destination and at the destination plus 4. Each such group uses up two elements. A word transfer with a count of 1 uses normal mode.
- R5: A start in paired mode raises the error flag when any of these holds: the count is odd, the index is not a multiple of 8, or either address is not 8-byte aligned.
- R6: Outside paired mode, read strobes are the element's lanes (0x01, 0x03 or 0x0F) shifted left by address bits [2:0]. Write strobes are the same lanes shifted by address bits [1:0] in bits [3:0], with bits [7:4] zero.
- R7: req_burst is high on a request only when the previous request of the same direction in the same transfer was exactly one beat lower or higher. A beat is 8 bytes for paired reads, 4 bytes for paired writes and the element size otherwise. The first request of each direction is never a burst.
- R8: done is a one-cycle pulse in the cycle after the last write is accepted. The block then accepts a new start. A start while a transfer runs is ignored.
- R9: A legal start with a count of zero gives done in the next cycle and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; sampled when idle |
| cfg_esize | input | 2 | Element size code |
| cfg_src_mode | input | 2 | Source update mode |
| cfg_dst_mode | input | 2 | Destination update mode |
| cfg_src | input | 32 | Source start address (64-bit port) |
| cfg_dst | input | 32 | Destination start address (32-bit port) |
| cfg_count | input | 16 | Element count |
| cfg_index | input | 16 | Signed element index in bytes |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted this cycle when high with req_valid |
| req_write | output | 1 | 1 = memory write, 0 = peripheral read |
| req_addr | output | 32 | Byte address of the request |
| req_strb | output | 8 | Byte-lane enables |
| req_burst | output | 1 | Beat is consecutive to the previous one of its direction |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal setup at the last start |

## Verification
Byte elements at an odd destination with index +1 step through every strobe lane and produce bursts on both sides. Half-words with a fixed source and an index of −2 tell a decrementing burst apart from a fixed address that repeats. Words with an index of 12 leave gaps, which must not be flagged as bursts. Paired mode is run with the source fixed and with the destination fixed, to separate the +4 second write from the index step. A one-word transfer with the source fixed shows that the count gate keeps normal mode. Each illegal setup, a zero count, a stalled handshake and a start while busy are each driven alone, so that a failure points to one rule.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {ES_WORD = 2'b00, ES_HALF = 2'b01, ES_BYTE = 2'b10, ES_RSVD = 2'b11} esize_t;
  typedef enum logic [1:0] {UM_FIXED = 2'b00, UM_INDEX = 2'b11} umode_t;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_WR2} st_t;

  function automatic logic [3:0] elem_bytes(input logic [1:0] es);
    case (es)
      2'b00:   return 4'd4;
      2'b01:   return 4'd2;
      2'b10:   return 4'd1;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [7:0] lane_mask(input logic [1:0] es);
    case (es)
      2'b00:   return 8'h0F;
      2'b01:   return 8'h03;
      2'b10:   return 8'h01;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/dag_param_check.sv
module dag_param_check
  import dag_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [1:0]    esize_i,
  input  logic [1:0]    smode_i,
  input  logic [1:0]    dmode_i,
  input  logic [2:0]    src_lsb_i,
  input  logic [2:0]    dst_lsb_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] index_i,
  output logic          illegal_o,
  output logic          paired_o
);
  logic [2:0] amask;
  logic       bad_size, bad_mode, bad_align, bad_pair;

  function automatic logic mode_ok(input logic [1:0] m);
    return (m == UM_FIXED) || (m == UM_INDEX);
  endfunction

  always_comb begin
    amask     = 3'(elem_bytes(esize_i) - 4'd1);
    bad_size  = (esize_i == ES_RSVD);
    bad_mode  = !mode_ok(smode_i) || !mode_ok(dmode_i);
    bad_align = |(src_lsb_i & amask) || |(dst_lsb_i & amask) || |(index_i[2:0] & amask);
    paired_o  = (esize_i == ES_WORD) && (smode_i == UM_FIXED || dmode_i == UM_FIXED) &&
                (count_i > CW'(1));
    bad_pair  = paired_o && (count_i[0] || |index_i[2:0] || |src_lsb_i || |dst_lsb_i);
    illegal_o = bad_size || bad_mode || bad_align || bad_pair;
  end
endmodule

// File: rtl/dag_strobe.sv
module dag_strobe
  import dag_pkg::*;
(
  input  logic       write_i,
  input  logic       paired_i,
  input  logic [1:0] esize_i,
  input  logic [2:0] lsb_i,
  output logic [7:0] strb_o
);
  logic [7:0] mask;
  logic [3:0] wlanes;

  always_comb begin
    mask   = lane_mask(esize_i);
    wlanes = mask[3:0] << lsb_i[1:0];
    if (!write_i) strb_o = paired_i ? 8'hFF : (mask << lsb_i);
    else          strb_o = {4'h0, wlanes};
  end
endmodule

// File: rtl/dag_burst_track.sv
module dag_burst_track #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          fire_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    beat_i,
  output logic          burst_o
);
  logic [AW-1:0] prev_addr [2];
  logic [1:0]    prev_v;

  function automatic logic adjacent(input logic [AW-1:0] p, input logic [AW-1:0] c,
                                    input logic [3:0] b);
    return (c == p + AW'(b)) || (p == c + AW'(b));
  endfunction

  for (genvar d = 0; d < 2; d++) begin : g_dir
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_addr[d] <= '0;
        prev_v[d]    <= 1'b0;
      end else if (clear_i) begin
        prev_v[d] <= 1'b0;
      end else if (fire_i && (write_i == 1'(d))) begin
        prev_addr[d] <= addr_i;
        prev_v[d]    <= 1'b1;
      end
    end
  end

  assign burst_o = prev_v[write_i] && adjacent(prev_addr[write_i], addr_i, beat_i);

  // R7: a burst beat never repeats the previous address of its direction
  assert_burst_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_o |-> addr_i != prev_addr[write_i]);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dag_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    cfg_esize,
  input  logic [1:0]    cfg_src_mode,
  input  logic [1:0]    cfg_dst_mode,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic [CW-1:0] cfg_index,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [7:0]    req_strb,
  output logic          req_burst,
  output logic          done,
  output logic          err
);
  localparam int XW = AW - CW;

  st_t           state;
  logic [AW-1:0] src_q, dst_q, idx_ext;
  logic [CW-1:0] left_q, idx_q;
  logic [1:0]    esize_q, smode_q, dmode_q;
  logic          paired_q, err_q, done_q;
  logic          illegal, paired, fire, accept, trk_burst, last_beat;
  logic [3:0]    beat;

  dag_param_check #(.CW(CW)) u_chk (
    .esize_i(cfg_esize), .smode_i(cfg_src_mode), .dmode_i(cfg_dst_mode),
    .src_lsb_i(cfg_src[2:0]), .dst_lsb_i(cfg_dst[2:0]), .count_i(cfg_count),
    .index_i(cfg_index), .illegal_o(illegal), .paired_o(paired));

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] m,
                                         input logic [AW-1:0] d);
    return (m == UM_INDEX) ? a + d : a;
  endfunction

  assign idx_ext   = {{XW{idx_q[CW-1]}}, idx_q};
  assign accept    = (state == ST_IDLE) && start;
  assign req_valid = (state != ST_IDLE);
  assign req_write = (state == ST_WR) || (state == ST_WR2);
  assign fire      = req_valid && req_ready;
  assign last_beat = (state == ST_WR2) ? (left_q == CW'(2)) : (left_q == CW'(1));
  assign beat      = paired_q ? (req_write ? 4'd4 : 4'd8) : elem_bytes(esize_q);
  assign done      = done_q;
  assign err       = err_q;

  always_comb begin
    case (state)
      ST_RD:   req_addr = src_q;
      ST_WR2:  req_addr = dst_q + AW'(4);
      default: req_addr = dst_q;
    endcase
  end

  dag_strobe u_strb (
    .write_i(req_write), .paired_i(paired_q), .esize_i(esize_q),
    .lsb_i(req_addr[2:0]), .strb_o(req_strb));

  dag_burst_track #(.AW(AW)) u_trk (
    .clk(clk), .rst_n(rst_n), .clear_i(accept), .fire_i(fire), .write_i(req_write),
    .addr_i(req_addr), .beat_i(beat), .burst_o(trk_burst));

  assign req_burst = req_valid && trk_burst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      left_q   <= '0;
      idx_q    <= '0;
      esize_q  <= '0;
      smode_q  <= '0;
      dmode_q  <= '0;
      paired_q <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          err_q <= illegal;
          if (!illegal) begin
            src_q    <= cfg_src;
            dst_q    <= cfg_dst;
            left_q   <= cfg_count;
            idx_q    <= cfg_index;
            esize_q  <= cfg_esize;
            smode_q  <= cfg_src_mode;
            dmode_q  <= cfg_dst_mode;
            paired_q <= paired;
            if (cfg_count == '0) done_q <= 1'b1;
            else                 state  <= ST_RD;
          end
        end
        ST_RD: if (fire) state <= ST_WR;
        default: if (fire) begin
          if (state == ST_WR && paired_q) begin
            state <= ST_WR2;
          end else begin
            left_q <= left_q - ((state == ST_WR2) ? CW'(2) : CW'(1));
            src_q  <= step(src_q, smode_q, idx_ext);
            dst_q  <= step(dst_q, dmode_q, idx_ext);
            if (last_beat) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state <= ST_RD;
            end
          end
        end
      endcase
    end
  end

  // R2: a stalled request holds still
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) &&
    $stable(req_strb));
  // R1: an error setup leaves the bus quiet
  assert_err_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !req_valid && !done);
  // R4: the paired second write sits one word above the first
  assert_pair_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && state == ST_WR && paired_q |=> req_valid && req_write &&
    req_addr == $past(req_addr) + AW'(4));
  // R6: byte writes enable exactly one lane
  assert_byte_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && esize_q == ES_BYTE |-> $countones(req_strb) == 1);
  // R8: done lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: an empty transfer finishes at once
  assert_zero_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !illegal && cfg_count == '0 |=> done && !req_valid);
endmodule

// File: tb/sim_dma_addr_gen.sv
`timescale 1ns/1ps
module sim_dma_addr_gen;
  logic        clk = 0, rst_n = 0, start = 0, req_ready = 1;
  logic [1:0]  cfg_esize = 0, cfg_src_mode = 0, cfg_dst_mode = 0;
  logic [31:0] cfg_src = 0, cfg_dst = 0;
  logic [15:0] cfg_count = 0, cfg_index = 0;
  logic        req_valid, req_write, req_burst, done, err;
  logic [31:0] req_addr;
  logic [7:0]  req_strb;
  int tests = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  dma_addr_gen u0 (.*);

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic kick(input logic [1:0] es, sm, dm, input logic [31:0] s, d,
                      input int cnt, input int idx);
    @(negedge clk);
    cfg_esize = es; cfg_src_mode = sm; cfg_dst_mode = dm;
    cfg_src = s; cfg_dst = d; cfg_count = 16'(cnt); cfg_index = 16'(idx);
    start = 1;
  endtask

  task automatic check_req(input string tag, input logic w, input logic [31:0] a,
                           input logic [7:0] sb, input logic b);
    @(negedge clk);
    start = 0;
    chk({tag, " req"}, {req_valid, req_write, req_addr, req_strb, req_burst},
        {1'b1, w, a, sb, b});
  endtask

  task automatic check_done(input string tag);
    @(negedge clk);
    chk({tag, " done R8"}, {req_valid, done, err}, {1'b0, 1'b1, 1'b0});
    @(negedge clk);
    chk({tag, " done pulse R8"}, {req_valid, done}, 2'b00);
  endtask

  // Reference model for R2 R3 R4 R6 R7 written from the requirements
  task automatic run_xfer(input string tag, input logic [1:0] es, sm, dm,
                          input logic [31:0] s0, d0, input int cnt, input int idx);
    logic [31:0] s, d, a, pr, pw;
    logic [7:0]  m, sb;
    bit pv, wv, wide, eb;
    int nb, k;
    s = s0; d = d0; pv = 0; wv = 0; pr = 0; pw = 0; k = 0;
    nb = (es == 0) ? 4 : (es == 1) ? 2 : 1;
    m = 8'((1 << nb) - 1);
    wide = (es == 0) && (sm == 0 || dm == 0) && cnt > 1;
    kick(es, sm, dm, s0, d0, cnt, idx);
    while (k < cnt) begin
      sb = wide ? 8'hFF : (m << s[2:0]);
      eb = pv && ((s == pr + (wide ? 8 : nb)) || (pr == s + (wide ? 8 : nb)));
      check_req(tag, 1'b0, s, sb, eb);
      pr = s; pv = 1;
      for (int w = 0; w < (wide ? 2 : 1); w++) begin
        a = d + 32'(4 * w);
        sb = (m << a[1:0]) & 8'h0F;
        eb = wv && ((a == pw + (wide ? 4 : nb)) || (pw == a + (wide ? 4 : nb)));
        check_req(tag, 1'b1, a, sb, eb);
        pw = a; wv = 1;
      end
      if (sm == 3) s = s + 32'(idx);
      if (dm == 3) d = d + 32'(idx);
      k += wide ? 2 : 1;
    end
    check_done(tag);
  endtask

  task automatic check_err(input string tag, input logic [1:0] es, sm, dm,
                           input logic [31:0] s, d, input int cnt, input int idx);
    kick(es, sm, dm, s, d, cnt, idx);
    @(negedge clk);
    start = 0;
    chk({tag, " err set"}, {err, req_valid, done}, 3'b100);
    @(negedge clk);
    chk({tag, " err quiet"}, {err, req_valid, done}, 3'b100);
  endtask

  task automatic t_reset();
    chk("reset R8", {req_valid, done, err}, 3'b000);
  endtask

  task automatic t_zero();  // R9
    kick(2'b10, 2'b11, 2'b11, 32'h40, 32'h80, 0, 1);
    @(negedge clk);
    start = 0;
    chk("zero count R9", {req_valid, done, err}, 3'b010);
    @(negedge clk);
    chk("zero count after R9", {req_valid, done}, 2'b00);
  endtask

  task automatic t_stall();  // R2
    req_ready = 0;
    kick(2'b10, 2'b00, 2'b00, 32'h10, 32'h20, 1, 0);
    check_req("stall R2 a", 1'b0, 32'h10, 8'h01, 1'b0);
    check_req("stall R2 b", 1'b0, 32'h10, 8'h01, 1'b0);
    req_ready = 1;
    check_req("stall R2 c", 1'b1, 32'h20, 8'h01, 1'b0);
    check_done("stall");
  endtask

  task automatic t_busy();  // R8: a start while busy is ignored
    kick(2'b10, 2'b11, 2'b11, 32'h0, 32'h100, 2, 1);
    check_req("busy R8 r0", 1'b0, 32'h0, 8'h01, 1'b0);
    start = 1; cfg_src = 32'h77; cfg_count = 16'd9;
    check_req("busy R8 w0", 1'b1, 32'h100, 8'h01, 1'b0);
    check_req("busy R8 r1", 1'b0, 32'h1, 8'h02, 1'b1);
    check_req("busy R8 w1", 1'b1, 32'h101, 8'h02, 1'b1);
    check_done("busy");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    run_xfer("bytes inc R2 R3 R6 R7", 2'b10, 2'b11, 2'b11, 32'h100, 32'h203, 5, 1);
    run_xfer("half dec R3 R7", 2'b01, 2'b00, 2'b11, 32'h12, 32'h40, 3, -2);
    run_xfer("word gaps R3 R7", 2'b00, 2'b11, 2'b11, 32'h1004, 32'h2000, 3, 12);
    run_xfer("paired src fixed R4", 2'b00, 2'b00, 2'b11, 32'h800, 32'h2000, 4, 8);
    run_xfer("paired dst fixed R4", 2'b00, 2'b11, 2'b00, 32'h900, 32'h3000, 4, 16);
    run_xfer("word single R4", 2'b00, 2'b00, 2'b11, 32'h804, 32'h10, 1, 8);
    check_err("size rsvd R1", 2'b11, 2'b00, 2'b00, 32'h0, 32'h0, 2, 0);
    check_err("mode 01 R1", 2'b10, 2'b01, 2'b00, 32'h0, 32'h0, 2, 0);
    check_err("half src odd R1", 2'b01, 2'b11, 2'b11, 32'h101, 32'h0, 2, 2);
    check_err("word dst R1", 2'b00, 2'b11, 2'b11, 32'h0, 32'h2, 2, 4);
    check_err("half index R1", 2'b01, 2'b11, 2'b11, 32'h0, 32'h0, 2, 3);
    check_err("paired odd R5", 2'b00, 2'b00, 2'b11, 32'h0, 32'h0, 3, 8);
    check_err("paired index R5", 2'b00, 2'b00, 2'b11, 32'h0, 32'h0, 4, 4);
    check_err("paired align R5", 2'b00, 2'b00, 2'b11, 32'h804, 32'h0, 4, 8);
    t_zero();
    t_stall();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule